// File: doc/BRIEF.md
# Block-Peak Amplitude Normalizer

This block takes a stream of signed ADC samples, at most one per clock, and rescales each one so that the output amplitude stays roughly constant while the input amplitude drifts. Samples are grouped into consecutive, non-overlapping blocks of `WIN` accepted samples. The largest magnitude seen in a block becomes the divisor for the samples that follow that block.

Once per block, a sequential divider turns that peak into a fixed-point reciprocal. Because of this, the per-sample datapath is only a multiply, a shift and a clamp, and its latency is fixed. The result is an 8-bit signed word with a valid strobe, intended for a parallel output bus with one bit per line. While the divider is working, the reciprocal from the earlier block stays in force. Until the first block has completed, the block scales as though the input were at full scale.

Top module: `peak_norm`

## Requirements
- R1: A block is exactly `WIN` (default 1000) accepted samples, where a sample is accepted on a cycle with `smp_valid` high. Blocks do not overlap: the sample accepted at count `WIN-1` closes the current block, and the next accepted sample opens a new one. Cycles with `smp_valid` low do not advance the count.
- R2: The block peak is the largest absolute value in the block, with -8192 taken as magnitude 8192. A block whose samples are all zero uses a peak of 1.
- R3: Each completed block produces a reciprocal equal to floor(8192 * 2^8 / peak). The first sample of the following block is still scaled by the earlier reciprocal. The new reciprocal is in force no later than 40 accepted samples into that block.
- R4: Between reset and the first completed block, the reciprocal is 256. This is the value a peak of 8192 would give, so every output equals the input clamped to 8 bits.
- R5: `norm_data` equals (sample * reciprocal) arithmetically shifted right by 8 bits, rounding toward minus infinity, then clamped to the range -128..127. It is presented in two's complement.
- R6: Each accepted sample produces exactly one output word, with `norm_valid` high exactly 2 clocks after the accepting edge. `norm_valid` is never high without such a sample.
- R7: A synchronous active-high reset does four things: it sets `norm_valid` and `norm_data` to 0, restarts the block count, clears the running peak, and returns the reciprocal to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 14 | Signed two's-complement sample |
| norm_valid | output | 1 | Output word valid |
| norm_data | output | 8 | Signed normalized sample |

## Verification
The hardest case to reach from the ports is the switch between reciprocals, because the old scale stays in use for a short stretch while the divider runs. The bench closes each block with its peak placed at the very last or very first position. It then checks the first sample of the next block against the old scale and the later samples against the new one. Gapped `smp_valid` streams, an all-zero block and a peak of -8192 cover the counting rule, the divisor clamp and the asymmetric magnitude. A reset in the middle of a block shows that a partial peak is discarded.

// File: rtl/pn_pkg.sv
package pn_pkg;
  typedef enum logic {DIV_IDLE, DIV_RUN} div_state_t;
endpackage

// File: rtl/pn_peak_track.sv
module pn_peak_track #(
  parameter int DW  = 14,
  parameter int WIN = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 blk_done,
  output logic [DW-1:0]        blk_peak
);
  localparam int CW = $clog2(WIN);

  logic [CW-1:0] cnt;
  logic [DW-1:0] run_max, mag, cand;
  logic          last;

  assign mag  = in_data[DW-1] ? (~in_data + 1'b1) : in_data;
  assign cand = (mag > run_max) ? mag : run_max;
  assign last = in_valid && (cnt == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      run_max  <= '0;
      blk_done <= 1'b0;
      blk_peak <= DW'(1);
    end else begin
      blk_done <= last;
      if (in_valid) begin
        if (last) begin
          cnt      <= '0;
          run_max  <= '0;
          blk_peak <= (cand == '0) ? DW'(1) : cand;
        end else begin
          cnt     <= cnt + 1'b1;
          run_max <= cand;
        end
      end
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(WIN));
  a_r1_done_restarts: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> (cnt == '0));
  a_r2_peak_nonzero: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> (blk_peak != '0));
endmodule

// File: rtl/pn_recip_div.sv
module pn_recip_div #(
  parameter int DW   = 14,
  parameter int NW   = 22,
  parameter int NUM  = 2097152,
  parameter int INIT = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] recip
);
  import pn_pkg::*;
  localparam int SW = $clog2(NW);

  div_state_t    state;
  logic [DW-1:0] acc, dv;
  logic [NW-1:0] quo;
  logic [SW-1:0] step;
  logic [DW:0]   trial;
  logic          fin;

  assign trial = {acc, quo[NW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DIV_IDLE;
      acc   <= '0;
      dv    <= DW'(1);
      quo   <= '0;
      step  <= '0;
      fin   <= 1'b0;
      recip <= NW'(INIT);
    end else begin
      fin <= 1'b0;
      if (fin) recip <= quo;
      if (state == DIV_IDLE) begin
        if (start) begin
          acc   <= '0;
          quo   <= NW'(NUM);
          dv    <= divisor;
          step  <= '0;
          state <= DIV_RUN;
        end
      end else begin
        if (trial >= {1'b0, dv}) begin
          acc <= DW'(trial - {1'b0, dv});
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          acc <= trial[DW-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
        step <= step + 1'b1;
        if (step == SW'(NW - 1)) begin
          state <= DIV_IDLE;
          fin   <= 1'b1;
        end
      end
    end
  end

  a_r3_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> (state == DIV_IDLE));
  a_r3_recip_hold: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(recip));
  a_r3_recip_nonzero: assert property (@(posedge clk) disable iff (rst)
    recip != '0);
endmodule

// File: rtl/pn_scale_pipe.sv
module pn_scale_pipe #(
  parameter int DW   = 14,
  parameter int NW   = 22,
  parameter int OW   = 8,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [NW-1:0]        recip,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int PW = DW + NW + 1;
  localparam logic signed [PW-1:0] HI = PW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  logic signed [PW-1:0] prod_q, shifted;
  logic                 v1;

  assign shifted = prod_q >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q    <= '0;
      v1        <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v1        <= in_valid;
      prod_q    <= PW'(in_data * $signed({1'b0, recip}));
      out_valid <= v1;
      if (shifted > HI)      out_data <= HI[OW-1:0];
      else if (shifted < LO) out_data <= LO[OW-1:0];
      else                   out_data <= shifted[OW-1:0];
    end
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  a_r5_sign: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data != '0) |-> (out_data[OW-1] == $past(in_data[DW-1], 2)));
endmodule

// File: rtl/peak_norm.sv
module peak_norm #(
  parameter int DW   = 14,
  parameter int OW   = 8,
  parameter int WIN  = 1000,
  parameter int GAIN = 8192,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  output logic                 norm_valid,
  output logic signed [OW-1:0] norm_data
);
  localparam int NUM  = GAIN << FRAC;
  localparam int NW   = $clog2(NUM + 1);
  localparam int INIT = NUM >> (DW - 1);

  logic          blk_done;
  logic [DW-1:0] blk_peak;
  logic [NW-1:0] recip;

  pn_peak_track #(.DW(DW), .WIN(WIN)) u_peak (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_data(smp_data),
    .blk_done(blk_done), .blk_peak(blk_peak)
  );

  pn_recip_div #(.DW(DW), .NW(NW), .NUM(NUM), .INIT(INIT)) u_div (
    .clk(clk), .rst(rst), .start(blk_done), .divisor(blk_peak), .recip(recip)
  );

  pn_scale_pipe #(.DW(DW), .NW(NW), .OW(OW), .FRAC(FRAC)) u_scale (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_data(smp_data),
    .recip(recip), .out_valid(norm_valid), .out_data(norm_data)
  );
endmodule

// File: tb/peak_norm_test.sv
module peak_norm_test;
  localparam int WIN = 1000;
  localparam longint NUM = 2097152;

  logic clk = 0, rst = 1, smp_valid = 0;
  logic signed [13:0] smp_data = '0;
  logic norm_valid;
  logic signed [7:0] norm_data;

  int errors = 0, checks = 0;
  string cur_tag = "R7";

  int mcnt = 0, runmax = 0, have_pend = 0;
  longint mrec = 256, pend = 0;
  int exp_q[$];
  bit chk_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  peak_norm uut (.clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
                 .norm_valid(norm_valid), .norm_data(norm_data));

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int model_out(int x, longint r);
    longint p = longint'(x) * r;
    p = p >>> 8;
    if (p > 127) return 127;
    if (p < -128) return -128;
    return int'(p);
  endfunction

  always @(negedge clk) begin
    if (!rst && norm_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected valid", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic bit c = chk_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (c) check(t, int'(norm_data), e);
      end
    end
  end

  task automatic send(int x);
    int idx = mcnt;
    int a = (x < 0) ? -x : x;
    if (have_pend != 0 && idx >= 40) begin mrec = pend; have_pend = 0; end
    exp_q.push_back(model_out(x, mrec));
    chk_q.push_back(!(have_pend != 0 && idx > 0));
    tag_q.push_back(cur_tag);
    if (a > runmax) runmax = a;
    mcnt++;
    if (mcnt == WIN) begin
      pend = NUM / ((runmax == 0) ? 1 : runmax);
      have_pend = 1; mcnt = 0; runmax = 0;
    end
    @(negedge clk); smp_valid = 1; smp_data = 14'(x);
    @(posedge clk);
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // fill out the current block; the peak sits at index pos
  task automatic close_block(int peak, int pos, bit gaps);
    for (int i = mcnt; i < WIN; i++) begin
      send((i == pos) ? peak : ((i % 5) - 2) * 3);
      if (gaps && (i % 7 == 0)) idle(2);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; smp_valid = 0;
    idle(2);
    check("R7 valid after reset", int'(norm_valid), 0);
    check("R7 data after reset", int'(norm_data), 0);
    rst = 0;
    mcnt = 0; runmax = 0; have_pend = 0; mrec = 256;
    exp_q.delete(); chk_q.delete(); tag_q.delete();
  endtask

  task automatic t_init_scale();
    cur_tag = "R4 R5 initial scale";
    send(50); send(-100); send(200); send(-300); send(0); send(127); send(-128);
    idle(3);
  endtask

  task automatic t_latency();
    cur_tag = "R6 latency";
    idle(4);
    send(17);
    check("R6 no valid after one edge", int'(norm_valid), 0);
    @(negedge clk);
    check("R6 valid after two edges", int'(norm_valid), 1);
    check("R6 data", int'(norm_data), 17);
    idle(2);
  endtask

  task automatic t_gapped_peak_last();
    cur_tag = "R1 gapped block, peak at last index";
    close_block(4000, WIN - 1, 1);
    cur_tag = "R3 handover after peak 4000";
    for (int i = 0; i < 60; i++) send((i % 2 == 1) ? 30 : -25);
  endtask

  task automatic t_neg_peak_first();
    cur_tag = "R2 negative peak";
    close_block(-20, 0, 0);
    send(-6000);
    close_block(0, -1, 0);
    cur_tag = "R2 R3 scale after peak -6000";
    for (int i = 0; i < 60; i++) send(i - 30);
  endtask

  task automatic t_zero_block();
    cur_tag = "R2 zero block";
    close_block(0, -1, 0);
    for (int i = mcnt; i < WIN; i++) send(0);
    cur_tag = "R2 clamp to one";
    for (int i = 0; i < 45; i++) send(0);
    send(1); send(0); send(-1); send(2);
  endtask

  task automatic t_most_negative();
    cur_tag = "R2 most negative";
    close_block(-8192, 500, 0);
    for (int i = 0; i < 45; i++) send(0);
    cur_tag = "R5 scale after -8192";
    send(100); send(-100); send(127); send(-129);
  endtask

  task automatic t_mid_reset();
    cur_tag = "R7 partial block";
    for (int i = 0; i < 300; i++) send((i == 10) ? 500 : 1);
    do_reset();
    cur_tag = "R7 initial scale after reset";
    for (int i = 0; i < 700; i++) send((i % 3) * 20);
    idle(3);
    cur_tag = "R1 R7 count restarted";
    close_block(1000, 999, 0);
    for (int i = 0; i < 60; i++) send(40);
  endtask

  initial begin
    int cyc = 0;
    fork
      begin
        do_reset();
        t_init_scale();
        t_latency();
        t_gapped_peak_last();
        t_neg_peak_first();
        t_zero_block();
        t_most_negative();
        t_mid_reset();
        idle(5);
        check("R6 all outputs seen", exp_q.size(), 0);
      end
      begin
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        check("watchdog", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule